// File: doc/BRIEF.md
# Serial Priority Chain Bus Arbiter

This block decides which of several devices may drive a shared bus by threading one priority signal through a row of identical per-device cells. The cell at the head of the row sees its incoming priority held high. A cell whose device is not requesting passes the incoming priority on to the next cell unchanged. A cell whose device is requesting, and which sees the incoming priority high, blocks the signal so that every cell further down sees it low. The one cell whose incoming priority is high and whose outgoing priority is low is the winner. Priority is therefore fixed by position, and device 0 at the head has the highest priority.

The winner is captured in a registered ownership state on the clock edge. The owner keeps the bus for as long as it holds its request, and a request from a device with higher priority does not take the bus away during that time. When the owner lowers its request, the bus is released on the next edge and stays free for one cycle. The chain picks the next owner on the edge after that. The priority line gives no fairness: a device far down the chain can wait for ever while devices nearer the head keep requesting.

The wrapper ties off the head of the chain. It reports the owner as a one-hot grant vector, as an index, and through a bus-busy flag.

Top module: `chain_bus_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released with no requests, grant is all zeros, busBusy is 0 and ownerId is 0.
- R2: If the bus is free and exactly one device k requests, then after the next rising edge grant has only bit k set, busBusy is 1 and ownerId equals k.
- R3: If the bus is free and several devices request together, the device with the lowest index is granted after the next edge. Device 0 is at the head of the chain and has the highest priority.
- R4: At most one bit of grant is set in any cycle.
- R5: While the owner keeps its request asserted, grant stays unchanged from cycle to cycle, even when a device with higher priority starts requesting.
- R6: In the cycle after the owner drops its request, grant is all zeros and busBusy is 0. On the edge after that, the highest-priority device that is still requesting is granted.
- R7: busBusy is 1 exactly when some bit of grant is set.
- R8: A grant bit rises only for a device whose request was asserted at the edge where the bit was captured.
- R9: A low-priority device that requests continuously is not granted while a higher-priority device re-requests in every free cycle. The starved device keeps its request pending.
- R10: While busBusy is 1, ownerId is the index of the set grant bit.
- R11: With no requests, the bus stays free with grant all zeros on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_DEV | Request per device, bit 0 at the head of the chain |
| grant | output | NUM_DEV | Registered one-hot owner of the bus, or zero when the bus is free |
| busBusy | output | 1 | High while some device owns the bus |
| ownerId | output | $clog2(NUM_DEV) | Index of the current owner, 0 when the bus is free |

## Verification
Embedded assertions check the following on every cycle:
- grant is one-hot or zero.
- The owner is held while it keeps requesting, and the bus is freed after it drops its request.
- A newly captured owner is the lowest-indexed device that was requesting.
- busBusy agrees with grant.
- ownerId points at the set grant bit.

Some behaviour only shows up in the bench's directed scenarios, because it depends on sequences of requests over several cycles. These scenarios cover:
- A higher-priority device arriving while a lower-priority device holds the bus, with no change of owner.
- The one free cycle between owners, followed by hand-over to the next requester in priority order.
- Starvation of the last device while the head device re-requests in every free cycle.

// File: rtl/chain_arb_pkg.sv
package chain_arb_pkg;

  typedef enum logic {
    BUS_FREE = 1'b0,
    BUS_HELD = 1'b1
  } busState_t;

  typedef struct packed {
    logic loadOwner;
    logic clearOwner;
  } ownerStrobe_t;

endpackage

// File: rtl/chain_cell.sv
module chain_cell (
  input  logic reqIn,
  input  logic prioIn,
  output logic prioOut,
  output logic winLocal
);

  // A requesting cell that sees priority blocks it for the cells below.
  assign prioOut  = prioIn & ~reqIn;
  // The cell with priority in high and priority out low wins the chain.
  assign winLocal = prioIn & ~prioOut;

endmodule

// File: rtl/chain_datapath.sv
module chain_datapath
  import chain_arb_pkg::*;
#(
  parameter int NUM_DEV = 4,
  localparam int IDW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] reqVec,
  input  ownerStrobe_t       strobe,
  output logic [NUM_DEV-1:0] ownerVec,
  output logic [IDW-1:0]     ownerIdx,
  output logic               chainIdle,
  output logic               ownerReq
);

  logic [NUM_DEV:0]   prioLine;
  logic [NUM_DEV-1:0] winVec;

  assign prioLine[0] = 1'b1;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cell
    chain_cell u_cell (
      .reqIn   (reqVec[i]),
      .prioIn  (prioLine[i]),
      .prioOut (prioLine[i+1]),
      .winLocal(winVec[i])
    );
  end

  // Priority still high past the last cell means nobody claimed it.
  assign chainIdle = prioLine[NUM_DEV];
  assign ownerReq  = |(ownerVec & reqVec);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerVec <= '0;
    end else if (strobe.clearOwner) begin
      ownerVec <= '0;
    end else if (strobe.loadOwner) begin
      ownerVec <= winVec;
    end
  end

  always_comb begin
    ownerIdx = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (ownerVec[i]) ownerIdx = IDW'(i);
    end
  end

  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ownerVec));

  assert_hold_owner_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((|ownerVec) && (|(ownerVec & reqVec))) |=> (ownerVec == $past(ownerVec)));

  assert_release_owner_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((|ownerVec) && !(|(ownerVec & reqVec))) |=> (ownerVec == '0));

  assert_head_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((ownerVec == '0) && (|reqVec)) |=> (ownerVec == ($past(reqVec) & (~$past(reqVec) + 1'b1))));

  assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ownerVec == '0) |=> ((ownerVec == '0) || ((ownerVec & $past(reqVec)) != '0)));

endmodule

// File: rtl/chain_control.sv
module chain_control
  import chain_arb_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         chainIdle,
  input  logic         ownerReq,
  output ownerStrobe_t strobe,
  output logic         busBusy
);

  busState_t state, stateNext;

  always_comb begin
    stateNext         = state;
    strobe.loadOwner  = 1'b0;
    strobe.clearOwner = 1'b0;
    unique case (state)
      BUS_FREE: begin
        if (!chainIdle) begin
          strobe.loadOwner = 1'b1;
          stateNext        = BUS_HELD;
        end
      end
      BUS_HELD: begin
        if (!ownerReq) begin
          strobe.clearOwner = 1'b1;
          stateNext         = BUS_FREE;
        end
      end
      default: stateNext = BUS_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= BUS_FREE;
    else       state <= stateNext;
  end

  assign busBusy = (state == BUS_HELD);

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadOwner && strobe.clearOwner));

endmodule

// File: rtl/chain_bus_arbiter.sv
module chain_bus_arbiter
  import chain_arb_pkg::*;
#(
  parameter int NUM_DEV = 4,
  localparam int IDW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] reqVec,
  output logic [NUM_DEV-1:0] grant,
  output logic               busBusy,
  output logic [IDW-1:0]     ownerId
);

  ownerStrobe_t strobe;
  logic         chainIdle;
  logic         ownerReq;

  chain_datapath #(.NUM_DEV(NUM_DEV)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .strobe   (strobe),
    .ownerVec (grant),
    .ownerIdx (ownerId),
    .chainIdle(chainIdle),
    .ownerReq (ownerReq)
  );

  chain_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .chainIdle(chainIdle),
    .ownerReq (ownerReq),
    .strobe   (strobe),
    .busBusy  (busBusy)
  );

  assert_busy_matches_R7: assert property (@(posedge clk) disable iff (!rstN)
    busBusy == (|grant));

  assert_owner_index_R10: assert property (@(posedge clk) disable iff (!rstN)
    busBusy |-> grant[ownerId]);

endmodule

// File: tb/chain_bus_arbiter_tb.sv
module chain_bus_arbiter_tb;

  localparam int N   = 4;
  localparam int IDW = $clog2(N);

  logic           clk = 1'b0;
  logic           rstN;
  logic [N-1:0]   reqVec;
  logic [N-1:0]   grant;
  logic           busBusy;
  logic [IDW-1:0] ownerId;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #4 clk = ~clk;

  chain_bus_arbiter #(.NUM_DEV(N)) u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .reqVec (reqVec),
    .grant  (grant),
    .busBusy(busBusy),
    .ownerId(ownerId)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectBus(input string tag, input logic [N-1:0] expGrant,
                           input logic expBusy, input logic [IDW-1:0] expId);
    checkCount++;
    if (grant !== expGrant || busBusy !== expBusy || ownerId !== expId) begin
      failCount++;
      $display("FAIL %s: grant=%b busy=%b id=%0d expected grant=%b busy=%b id=%0d",
               tag, grant, busBusy, ownerId, expGrant, expBusy, expId);
    end
  endtask

  task automatic doReset();
    reqVec = '0;
    rstN   = 1'b0;
    step();
    step();
    expectBus("R1 in reset", 4'b0000, 1'b0, 2'd0);
    rstN = 1'b1;
    step();
    expectBus("R1 after reset", 4'b0000, 1'b0, 2'd0);
  endtask

  task automatic testSingle();
    for (int k = 0; k < N; k++) begin
      reqVec = N'(1) << k;
      step();
      expectBus("R2 single requester", N'(1) << k, 1'b1, IDW'(k));
      expectBus("R10 owner index", N'(1) << k, 1'b1, IDW'(k));
      reqVec = '0;
      step();
      expectBus("R6 free after single", 4'b0000, 1'b0, 2'd0);
    end
  endtask

  task automatic testPriority();
    reqVec = 4'b1110;
    step();
    expectBus("R3 lowest index wins", 4'b0010, 1'b1, 2'd1);
    reqVec = '0;
    step();
    reqVec = 4'b1111;
    step();
    expectBus("R3 head wins", 4'b0001, 1'b1, 2'd0);
    reqVec = '0;
    step();
    expectBus("R7 busy low when free", 4'b0000, 1'b0, 2'd0);
  endtask

  task automatic testNoPreempt();
    reqVec = 4'b1000;
    step();
    expectBus("R2 device 3 owns", 4'b1000, 1'b1, 2'd3);
    reqVec = 4'b1001;
    step();
    expectBus("R5 no preemption", 4'b1000, 1'b1, 2'd3);
    step();
    expectBus("R5 still held", 4'b1000, 1'b1, 2'd3);
    reqVec = 4'b0001;
    step();
    expectBus("R6 free cycle after release", 4'b0000, 1'b0, 2'd0);
    step();
    expectBus("R6 next requester granted", 4'b0001, 1'b1, 2'd0);
    reqVec = '0;
    step();
    expectBus("R6 free after head release", 4'b0000, 1'b0, 2'd0);
  endtask

  task automatic testStarve();
    reqVec = 4'b1001;
    step();
    expectBus("R9 head takes bus", 4'b0001, 1'b1, 2'd0);
    for (int r = 0; r < 3; r++) begin
      reqVec = 4'b1000;
      step();
      expectBus("R9 free cycle", 4'b0000, 1'b0, 2'd0);
      reqVec = 4'b1001;
      step();
      expectBus("R9 device 3 starved", 4'b0001, 1'b1, 2'd0);
    end
    reqVec = 4'b1000;
    step();
    step();
    expectBus("R8 starved device finally granted", 4'b1000, 1'b1, 2'd3);
    reqVec = '0;
    step();
    expectBus("R6 free at end", 4'b0000, 1'b0, 2'd0);
  endtask

  task automatic testIdle();
    reqVec = '0;
    for (int c = 0; c < 4; c++) begin
      step();
      expectBus("R11 stays free", 4'b0000, 1'b0, 2'd0);
    end
  endtask

  initial begin
    @(negedge clk);
    doReset();
    testSingle();
    testPriority();
    testNoPreempt();
    testStarve();
    testIdle();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule